// File: doc/BRIEF.md
# Stack Frame Cache

This block is a small direct-mapped store for loads and stores made relative to the stack pointer. The requester presents a word offset from the current frame base instead of an address. The low offset bits pick the entry directly, so a lookup needs no address translation and no wide tag compare. Each entry carries a short tag: the frame depth that wrote it. A call raises the depth and a return lowers it. The entries of the frame being popped are dropped without being written back, because the data in a dead frame has no further use.

Frames at even depth index the array with the offset bits as given. Frames at odd depth use the inverted offset bits, so a caller and its callee fill the array from opposite ends. Only offsets below the array size minus a reserved chunk are cached. Each parity therefore owns a reserved chunk at its own end of the array (8 entries, 64 bytes, by default) that the other parity never reaches. An access at a larger offset goes straight to the backing store.

A load miss fetches the word from a simple backing-store port and holds the requester in a stall until the fetch returns. A store miss claims the entry without a fetch. A dirty entry of another frame is written back before it is replaced. Backing-store addresses are built as the frame depth above the word offset.

Top module: `stack_frame_cache`

## Requirements
- R1: With the default parameters (32 entries), a frame at even depth maps word offset o to entry o[4:0], and a frame at odd depth maps it to entry ~o[4:0]. A caller at offset 10 and its callee at offset 21 therefore share an entry.
- R2: Offsets 0 to 7 of an even frame and offsets 0 to 7 of an odd frame use disjoint entries. Filling both causes no backing traffic, and all sixteen words read back as hits afterwards.
- R3: An access with offset 24 or more goes only to the backing store, with bsAddr = {depth, offset}. The response has rspHit = 0 and the access allocates no entry, so repeating it misses again.
- R4: A load that hits is accepted with stall low. In the next cycle it returns rspValid = 1, rspHit = 1 and the stored word.
- R5: A store that hits updates the entry on its accepting edge and responds the next cycle with rspHit = 1, with rspData echoing the written word. A later load returns the new word.
- R6: A load miss without a dirty victim holds stall high and issues a backing read at {depth, offset}. On the cycle bsAck is high it is accepted, and the next cycle it returns bsRData with rspHit = 0. The entry then holds that word, clean.
- R7: A store miss without a dirty victim is accepted with stall low and issues no backing request. It responds the next cycle with rspHit = 0 and the written word.
- R8: Before a miss replaces a valid dirty entry, the block issues a backing write of that entry's data. The write goes to {entry tag, offset rebuilt from the entry number and the tag parity}, and stall stays high until it is acknowledged.
- R9: A call raises the depth by one, saturating at 15. A return lowers it by one and invalidates every entry tagged with the depth being left, with no writeback. The caller's own entries still hit after the return.
- R10: A return at depth 0 is ignored: the depth stays 0 and no entry is invalidated.
- R11: After a synchronous reset, stall, rspValid and bsReq are low, the depth is 0 and every entry is invalid.
- R12: Call and return are honoured only in a cycle with no request waiting (stall low and no backing transfer in progress). A call and a return together have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request present; held with its fields until accepted (stall low) |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqOff | input | OFF_W | Word offset from the frame base |
| reqWData | input | DATA_W | Store data |
| stall | output | 1 | Request cannot be accepted this cycle |
| rspValid | output | 1 | Response for the request accepted at the previous edge |
| rspData | output | DATA_W | Load data, or the store data echoed back |
| rspHit | output | 1 | Request was served from the array |
| callEvt | input | 1 | Enter a new frame |
| retEvt | input | 1 | Leave the current frame |
| bsReq | output | 1 | Backing-store transfer requested |
| bsWrite | output | 1 | Backing transfer is a write |
| bsAddr | output | DEPTH_W+OFF_W | Backing address {depth, word offset} |
| bsWData | output | DATA_W | Backing write data |
| bsAck | input | 1 | Backing transfer complete this cycle |
| bsRData | input | DATA_W | Backing read data, valid with bsAck |

## Verification
Repeated loads and stores at one offset separate the hit paths from the miss paths. A caller at offset 10 and a callee at offset 21 shows whether odd frames invert the index and whether the dirty victim is written back to the address it came from. Filling offsets 0 to 7 in adjacent frames shows that the reserved chunks stay apart. Returns at depth zero, accesses beyond the offset limit, and a long random mix of calls, returns, loads and stores check the frame tagging and the stall timing against a behavioural model.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WBACK,
    ST_FILL,
    ST_BYPASS
  } ctlState_e;

  typedef enum logic [1:0] {
    RSP_ENTRY,
    RSP_BACK,
    RSP_WDATA
  } rspSrc_e;

  typedef struct packed {
    logic    fillEntry;
    logic    storeEntry;
    logic    cleanEntry;
    logic    dropFrame;
    logic    bsVictim;
    logic    rspCap;
    logic    rspHit;
    rspSrc_e rspSrc;
  } ctlStrobe_t;

endpackage

// File: rtl/sfc_datapath.sv
module sfc_datapath
  import sfc_pkg::*;
#(
  parameter int DATA_W      = 64,
  parameter int ENTRIES     = 32,
  parameter int RSV_ENTRIES = 8,
  parameter int OFF_W       = 8,
  parameter int DEPTH_W     = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [OFF_W-1:0]         reqOff,
  input  logic [DATA_W-1:0]        reqWData,
  input  logic [DEPTH_W-1:0]       depth,
  input  logic [DATA_W-1:0]        bsRData,
  input  ctlStrobe_t               strb,
  output logic                     inRange,
  output logic                     entValid,
  output logic                     entDirty,
  output logic [DEPTH_W-1:0]       entTag,
  output logic [DEPTH_W+OFF_W-1:0] bsAddr,
  output logic [DATA_W-1:0]        bsWData,
  output logic                     rspValid,
  output logic [DATA_W-1:0]        rspData,
  output logic                     rspHit
);

  localparam int IDX_W = $clog2(ENTRIES);
  localparam int LIMIT = ENTRIES - RSV_ENTRIES;

  logic [IDX_W-1:0]   idx;
  logic [IDX_W-1:0]   victimIdx;
  logic [OFF_W-1:0]   victimOff;
  logic [DATA_W-1:0]  entData;
  logic [ENTRIES-1:0] validVec;
  logic [ENTRIES-1:0] dirtyVec;
  logic [DEPTH_W-1:0] tagArr  [ENTRIES];
  logic [DATA_W-1:0]  dataArr [ENTRIES];

  // odd frames walk the array from the far end
  always_comb begin
    idx       = depth[0] ? ~reqOff[IDX_W-1:0] : reqOff[IDX_W-1:0];
    inRange   = (reqOff < OFF_W'(LIMIT));
    entValid  = validVec[idx];
    entDirty  = dirtyVec[idx];
    entTag    = tagArr[idx];
    entData   = dataArr[idx];
    victimIdx = entTag[0] ? ~idx : idx;
    victimOff = OFF_W'(victimIdx);
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic               sel;
    logic               vQ;
    logic               dQ;
    logic [DEPTH_W-1:0] tQ;
    logic [DATA_W-1:0]  wQ;

    assign sel = (idx == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (rst) begin
        vQ <= 1'b0;
        dQ <= 1'b0;
      end else if (strb.dropFrame && vQ && (tQ == depth)) begin
        vQ <= 1'b0;
        dQ <= 1'b0;
      end else if (sel && (strb.fillEntry || strb.storeEntry)) begin
        vQ <= 1'b1;
        dQ <= strb.storeEntry;
      end else if (sel && strb.cleanEntry) begin
        dQ <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (sel && (strb.fillEntry || strb.storeEntry)) tQ <= depth;
      if (sel && strb.fillEntry)       wQ <= bsRData;
      else if (sel && strb.storeEntry) wQ <= reqWData;
    end

    assign validVec[e] = vQ;
    assign dirtyVec[e] = dQ;
    assign tagArr[e]   = tQ;
    assign dataArr[e]  = wQ;
  end

  always_comb begin
    if (strb.bsVictim) begin
      bsAddr  = {entTag, victimOff};
      bsWData = entData;
    end else begin
      bsAddr  = {depth, reqOff};
      bsWData = reqWData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rspValid <= 1'b0;
    else     rspValid <= strb.rspCap;
    if (strb.rspCap) begin
      rspHit <= strb.rspHit;
      case (strb.rspSrc)
        RSP_ENTRY: rspData <= entData;
        RSP_BACK:  rspData <= bsRData;
        default:   rspData <= reqWData;
      endcase
    end
  end

  // R8
  dirty_victim_chk: assert property (@(posedge clk) disable iff (rst)
    ((strb.fillEntry || strb.storeEntry) && entValid && entDirty) |-> (entTag == depth));

endmodule

// File: rtl/sfc_control.sv
module sfc_control
  import sfc_pkg::*;
#(
  parameter int DEPTH_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic               callEvt,
  input  logic               retEvt,
  input  logic               inRange,
  input  logic               entValid,
  input  logic               entDirty,
  input  logic [DEPTH_W-1:0] entTag,
  input  logic               bsAck,
  input  logic               rspValid,
  input  logic               rspHit,
  output logic [DEPTH_W-1:0] depth,
  output logic               stall,
  output logic               bsReq,
  output logic               bsWrite,
  output ctlStrobe_t         strb
);

  localparam logic [DEPTH_W-1:0] DEPTH_MAX = {DEPTH_W{1'b1}};

  ctlState_e state;
  ctlState_e nxtState;
  logic      hit;
  logic      evtOk;
  logic      doCall;
  logic      doRet;

  always_comb begin
    hit      = inRange && entValid && (entTag == depth);
    strb     = '0;
    stall    = 1'b0;
    bsReq    = 1'b0;
    bsWrite  = 1'b0;
    nxtState = state;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          if (!inRange) begin
            stall    = 1'b1;
            nxtState = ST_BYPASS;
          end else if (hit) begin
            strb.storeEntry = reqWrite;
            strb.rspCap     = 1'b1;
            strb.rspHit     = 1'b1;
            strb.rspSrc     = reqWrite ? RSP_WDATA : RSP_ENTRY;
          end else if (entValid && entDirty) begin
            stall    = 1'b1;
            nxtState = ST_WBACK;
          end else if (reqWrite) begin
            strb.storeEntry = 1'b1;
            strb.rspCap     = 1'b1;
            strb.rspSrc     = RSP_WDATA;
          end else begin
            stall    = 1'b1;
            nxtState = ST_FILL;
          end
        end
      end
      ST_WBACK: begin
        bsReq         = 1'b1;
        bsWrite       = 1'b1;
        strb.bsVictim = 1'b1;
        stall         = 1'b1;
        if (bsAck) begin
          strb.cleanEntry = 1'b1;
          nxtState        = ST_IDLE;
        end
      end
      ST_FILL: begin
        bsReq = 1'b1;
        stall = !bsAck;
        if (bsAck) begin
          strb.fillEntry = 1'b1;
          strb.rspCap    = 1'b1;
          strb.rspSrc    = RSP_BACK;
          nxtState       = ST_IDLE;
        end
      end
      default: begin
        bsReq   = 1'b1;
        bsWrite = reqWrite;
        stall   = !bsAck;
        if (bsAck) begin
          strb.rspCap = 1'b1;
          strb.rspSrc = reqWrite ? RSP_WDATA : RSP_BACK;
          nxtState    = ST_IDLE;
        end
      end
    endcase
    evtOk          = (state == ST_IDLE) && !stall;
    doCall         = evtOk && callEvt && !retEvt && (depth != DEPTH_MAX);
    doRet          = evtOk && retEvt && !callEvt && (depth != '0);
    strb.dropFrame = doRet;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      depth <= '0;
    end else begin
      state <= nxtState;
      if (doCall)     depth <= depth + 1'b1;
      else if (doRet) depth <= depth - 1'b1;
    end
  end

  // R4
  hit_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && reqValid && !stall && inRange && entValid && entTag == depth)
      |=> (rspValid && rspHit));

  // R6
  fill_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FILL && bsAck) |=> (rspValid && !rspHit));

  // R7
  store_nofetch_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && reqValid && reqWrite && inRange && !(entValid && entDirty))
      |=> !bsReq);

  // R10
  ret_floor_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !stall && retEvt && !callEvt && depth == '0) |=> (depth == '0));

endmodule

// File: rtl/stack_frame_cache.sv
module stack_frame_cache
  import sfc_pkg::*;
#(
  parameter int DATA_W      = 64,
  parameter int ENTRIES     = 32,
  parameter int RSV_ENTRIES = 8,
  parameter int OFF_W       = 8,
  parameter int DEPTH_W     = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     reqValid,
  input  logic                     reqWrite,
  input  logic [OFF_W-1:0]         reqOff,
  input  logic [DATA_W-1:0]        reqWData,
  output logic                     stall,
  output logic                     rspValid,
  output logic [DATA_W-1:0]        rspData,
  output logic                     rspHit,
  input  logic                     callEvt,
  input  logic                     retEvt,
  output logic                     bsReq,
  output logic                     bsWrite,
  output logic [DEPTH_W+OFF_W-1:0] bsAddr,
  output logic [DATA_W-1:0]        bsWData,
  input  logic                     bsAck,
  input  logic [DATA_W-1:0]        bsRData
);

  ctlStrobe_t         strb;
  logic [DEPTH_W-1:0] depth;
  logic [DEPTH_W-1:0] entTag;
  logic               inRange;
  logic               entValid;
  logic               entDirty;

  sfc_control #(.DEPTH_W(DEPTH_W)) u_ctl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .callEvt(callEvt), .retEvt(retEvt), .inRange(inRange),
    .entValid(entValid), .entDirty(entDirty), .entTag(entTag),
    .bsAck(bsAck), .rspValid(rspValid), .rspHit(rspHit), .depth(depth),
    .stall(stall), .bsReq(bsReq), .bsWrite(bsWrite), .strb(strb)
  );

  sfc_datapath #(
    .DATA_W(DATA_W), .ENTRIES(ENTRIES), .RSV_ENTRIES(RSV_ENTRIES),
    .OFF_W(OFF_W), .DEPTH_W(DEPTH_W)
  ) u_dp (
    .clk(clk), .rst(rst), .reqOff(reqOff), .reqWData(reqWData),
    .depth(depth), .bsRData(bsRData), .strb(strb), .inRange(inRange),
    .entValid(entValid), .entDirty(entDirty), .entTag(entTag),
    .bsAddr(bsAddr), .bsWData(bsWData), .rspValid(rspValid),
    .rspData(rspData), .rspHit(rspHit)
  );

endmodule

// File: tb/tb_stack_frame_cache.sv
`timescale 1ns/1ps
module tb_stack_frame_cache;

  localparam int ENT   = 32;
  localparam int LIMIT = 24;
  localparam int DMAX  = 15;

  typedef struct {
    bit          wr;
    int          addr;
    logic [63:0] data;
  } bsOp_t;

  logic        clk = 0;
  logic        rst = 1;
  logic        reqValid = 0, reqWrite = 0, callEvt = 0, retEvt = 0, bsAck = 0;
  logic [7:0]  reqOff = 0;
  logic [63:0] reqWData = 0, bsRData = 0;
  logic        stall, rspValid, rspHit, bsReq, bsWrite;
  logic [63:0] rspData, bsWData;
  logic [11:0] bsAddr;

  stack_frame_cache dut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqOff(reqOff), .reqWData(reqWData), .stall(stall), .rspValid(rspValid),
    .rspData(rspData), .rspHit(rspHit), .callEvt(callEvt), .retEvt(retEvt),
    .bsReq(bsReq), .bsWrite(bsWrite), .bsAddr(bsAddr), .bsWData(bsWData),
    .bsAck(bsAck), .bsRData(bsRData)
  );

  always #5 clk = ~clk;

  int nChecks = 0;
  int nFail   = 0;

  // behavioural model
  int          mDepth = 0;
  bit          mValid [ENT];
  bit          mDirty [ENT];
  int          mTag   [ENT];
  logic [63:0] mData  [ENT];
  logic [63:0] expMem [int];
  logic [63:0] bsMem  [int];
  bsOp_t       expQ [$];
  int          lat = 0;

  function automatic logic [63:0] initWord(int a);
    return 64'hA5C3_0000_0000_0000 ^ (64'(a) * 64'h9E37_79B9_7F4A_7C15);
  endfunction

  function automatic logic [63:0] expRd(int a);
    return expMem.exists(a) ? expMem[a] : initWord(a);
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // backing store: acknowledges every transfer two cycles after it appears
  always @(negedge clk) begin
    if (rst) begin
      bsAck = 0;
      lat   = 0;
    end else if (bsAck) begin
      bsAck = 0;
      lat   = 0;
    end else if (bsReq) begin
      lat++;
      if (lat == 2) begin
        if (expQ.size() == 0) begin
          chk(0, "R8", "unexpected backing transfer", 64'(bsAddr), 0);
        end else begin
          bsOp_t op;
          op = expQ.pop_front();
          chk(bsWrite == op.wr, "R6", "backing direction", 64'(bsWrite), 64'(op.wr));
          chk(int'(bsAddr) == op.addr, "R8", "backing address", 64'(bsAddr), 64'(op.addr));
          if (op.wr) chk(bsWData == op.data, "R8", "backing write data", bsWData, op.data);
        end
        if (bsWrite) bsMem[int'(bsAddr)] = bsWData;
        else bsRData = bsMem.exists(int'(bsAddr)) ? bsMem[int'(bsAddr)] : initWord(int'(bsAddr));
        bsAck = 1;
      end
    end
  end

  task automatic doReq(bit wr, int off, logic [63:0] wd, string note);
    bsOp_t       op;
    logic [63:0] expData;
    bit          expHit;
    string       t;
    bit          first;
    int          i, a;
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqOff = 8'(off); reqWData = wd;
    expQ.delete();
    a = mDepth * 256 + off;
    if (off >= LIMIT) begin
      t = "R3"; expHit = 0;
      op.wr = wr; op.addr = a; op.data = wd; expQ.push_back(op);
      if (wr) begin expMem[a] = wd; expData = wd; end
      else expData = expRd(a);
    end else begin
      i = (mDepth % 2) ? (~off & (ENT - 1)) : (off & (ENT - 1));
      if (mValid[i] && mTag[i] == mDepth) begin
        expHit = 1;
        if (wr) begin mData[i] = wd; mDirty[i] = 1; expData = wd; t = "R5"; end
        else begin expData = mData[i]; t = "R4"; end
      end else begin
        expHit = 0;
        t = wr ? "R7" : "R6";
        if (mValid[i] && mDirty[i]) begin
          int vo;
          vo = (mTag[i] % 2) ? (~i & (ENT - 1)) : i;
          op.wr = 1; op.addr = mTag[i] * 256 + vo; op.data = mData[i];
          expQ.push_back(op);
          expMem[op.addr] = mData[i];
          t = "R8";
        end
        if (wr) begin
          mData[i] = wd; mDirty[i] = 1; expData = wd;
        end else begin
          op.wr = 0; op.addr = a; op.data = 0; expQ.push_back(op);
          mData[i] = expRd(a); mDirty[i] = 0; expData = mData[i];
        end
        mValid[i] = 1; mTag[i] = mDepth;
      end
    end
    t = {t, " ", note};
    first = 1;
    forever begin
      #1;
      if (first) chk(stall == (expQ.size() != 0), t, "stall on issue", 64'(stall), 64'(expQ.size() != 0));
      first = 0;
      if (rspValid) chk(0, t, "response before acceptance", 1, 0);
      if (!stall) break;
      @(negedge clk);
    end
    @(posedge clk);
    @(negedge clk);
    reqValid = 0;
    chk(rspValid == 1, t, "rspValid", 64'(rspValid), 1);
    chk(rspHit == expHit, t, "rspHit", 64'(rspHit), 64'(expHit));
    chk(rspData == expData, t, "rspData", rspData, expData);
    chk(expQ.size() == 0, t, "pending backing transfers", 64'(expQ.size()), 0);
  endtask

  task automatic doCall();
    @(negedge clk); callEvt = 1;
    @(negedge clk); callEvt = 0;
    if (mDepth < DMAX) mDepth++;
  endtask

  task automatic doRet();
    @(negedge clk); retEvt = 1;
    @(negedge clk); retEvt = 0;
    if (mDepth > 0) begin
      for (int k = 0; k < ENT; k++)
        if (mValid[k] && mTag[k] == mDepth) begin mValid[k] = 0; mDirty[k] = 0; end
      mDepth--;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    for (int k = 0; k < ENT; k++) begin mValid[k] = 0; mDirty[k] = 0; mTag[k] = 0; mData[k] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    @(negedge clk);
    chk(stall == 0, "R11", "stall after reset", 64'(stall), 0);
    chk(rspValid == 0, "R11", "rspValid after reset", 64'(rspValid), 0);
    chk(bsReq == 0, "R11", "bsReq after reset", 64'(bsReq), 0);

    doReq(0, 0, 0, "R11 first load misses");
    doReq(0, 0, 0, "repeat load hits");
    doReq(1, 3, 64'h1111_2222_3333_4444, "store miss");
    doReq(0, 3, 0, "readback");
    doReq(1, 3, 64'h5555_6666_7777_8888, "store hit");
    doReq(0, 3, 0, "readback new");

    // R2: reserved ends of adjacent frames
    for (int o = 0; o < 8; o++) doReq(1, o, 64'(o) + 64'hE000, "R2 even fill");
    doCall();
    for (int o = 0; o < 8; o++) doReq(1, o, 64'(o) + 64'hD000, "R2 odd fill");
    for (int o = 0; o < 8; o++) doReq(0, o, 0, "R2 odd readback");
    doRet();
    for (int o = 0; o < 8; o++) doReq(0, o, 0, "R2 R9 even readback after return");

    // R1/R8: caller offset 10 and callee offset 21 share an entry
    doReq(1, 10, 64'hCA11_E000_0000_000A, "R1 caller store");
    doCall();
    doReq(1, 21, 64'hCA11_EE00_0000_0015, "R1 callee evicts caller");
    doReq(0, 21, 0, "R1 callee readback");
    doRet();
    doReq(0, 10, 0, "R9 caller refetches written-back word");
    doCall();
    doReq(0, 21, 0, "R9 popped dirty data discarded");
    doRet();

    // R3: beyond the offset limit
    doReq(1, 24, 64'hB1B1_0000_0000_0018, "R3 bypass store");
    doReq(0, 24, 0, "R3 bypass load");
    doReq(0, 24, 0, "R3 no allocation");
    doReq(0, 200, 0, "R3 far offset");

    // R10: return at depth 0
    doReq(1, 5, 64'h0F0F_0000_0000_0005, "R10 setup");
    doRet();
    doReq(0, 5, 0, "R10 entry kept after return at depth 0");

    // R12: call together with return changes nothing
    @(negedge clk); callEvt = 1; retEvt = 1;
    @(negedge clk); callEvt = 0; retEvt = 0;
    doReq(0, 5, 0, "R12 simultaneous events ignored");

    // R9: saturation at the top depth
    for (int k = 0; k < 17; k++) doCall();
    doReq(1, 2, 64'h7777_0000_0000_0002, "R9 deepest frame");
    doRet();
    doReq(0, 2, 0, "R9 frame 14 view");
    for (int k = 0; k < 14; k++) doRet();

    // random mix
    for (int n = 0; n < 400; n++) begin
      int r;
      r = $urandom % 100;
      if (r < 8) doCall();
      else if (r < 16) doRet();
      else begin
        int off;
        off = ($urandom % 12 == 0) ? (24 + $urandom % 232) : ($urandom % 32);
        doReq(bit'($urandom % 2), off, {$urandom, $urandom}, "random");
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule